// File: doc/BRIEF.md
# High-Memory RAM Card Switch Controller

This block holds the soft-switch state of a 16 KB RAM expansion card that sits over the upper ROM area of an 8-bit, 6502-style bus. It watches every qualified bus access. When an access falls in a 16-address switch window, the block decodes the low address bits and the read/write strobe to update three pieces of state:

- whether reads of the high region come from card RAM or from ROM,
- whether writes to the high region reach card RAM,
- which of the two 4 KB banks backs the lowest 4 KB of that region.

Write enabling is guarded. An odd-numbered switch must be read twice in a row, with no other switch access in between, before writes are let through. A small saturating pre-write counter tracks this. The block also routes each high-region access to RAM or ROM, based on its direction and the current state. The RAM arrays, the ROM and the bus arbitration sit outside this block.

Top module: `hiram_switch_ctrl`

## Requirements
- R1: After reset is released, bank1_sel is 0 (bank 2 selected), ram_rd_en is 0 and ram_wr_en is 0.
- R2: Only a qualified access (bus_valid=1) with bus_addr in 0xC080..0xC08F changes the state. Accesses outside that window, or with bus_valid=0, leave ram_rd_en, ram_wr_en and bank1_sel unchanged.
- R3: A switch access with address bit 3 equal to 1 sets bank1_sel to 1 (bank 1). With bit 3 equal to 0 it sets bank1_sel to 0 (bank 2). This holds for reads and writes.
- R4: A switch access whose two low address bits are 00 or 11 sets ram_rd_en to 1. Low bits 01 or 10 set it to 0. This holds for reads and writes.
- R5: Address bit 2 has no effect: offset k and offset k XOR 4 give the same resulting state.
- R6: A read of an odd offset (bit 0 equal to 1) advances a pre-write count that saturates at 2. ram_wr_en is 1 exactly while that count is 2, so a second consecutive odd read enables writes.
- R7: A write to an odd offset, or any access to an even offset, clears the pre-write count, so ram_wr_en becomes 0.
- R8: A single odd read after the count was cleared leaves ram_wr_en at 0. The sequence odd read, odd write, odd read also leaves it at 0.
- R9: ram_route is 1 only for a qualified access with bus_addr at or above 0xD000. For such an access it equals ram_rd_en when bus_rnw=1 and ram_wr_en when bus_rnw=0. It is 0 for every other access.
- R10: A switch access presented in one cycle updates the state on the next rising clock edge. The registered outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access qualifier strobe |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Access address |
| ram_rd_en | output | 1 | High-region reads come from card RAM |
| ram_wr_en | output | 1 | High-region writes reach card RAM |
| bank1_sel | output | 1 | 1 = bank 1, 0 = bank 2 for 0xD000..0xDFFF |
| ram_route | output | 1 | Current access is served by card RAM |

## Verification
The three state outputs are registered. A switch access driven on a falling edge therefore shows up on them after exactly one rising edge. The bench samples them on the next falling edge, and it also checks that they are still unchanged one nanosecond after the inputs were driven.

ram_route is combinational from the current access and the present state. It is sampled in the same half cycle in which the access is driven, before any edge can change that state.

The exhaustive sweep covers all 16 offsets in both directions. It starts from each of the three pre-write counts, and a bench model predicts every result from the requirement rules.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  // Decoded view of one qualified switch-window access
  typedef struct packed {
    logic hit;     // qualified access inside the switch window
    logic is_rd;   // access direction is a read
    logic odd;     // offset bit 0
    logic rd_ram;  // offset selects reads from card RAM
    logic bank1;   // offset selects bank 1
  } sw_access_t;
endpackage

// File: rtl/hrc_rst_sync.sv
module hrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/hrc_window_decode.sv
module hrc_window_decode
  import hrc_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'hC080
) (
  input  logic        valid,
  input  logic        rnw,
  input  logic [15:4] addr_page,
  input  logic        sel_bank,   // address bit 3
  input  logic [1:0]  sel_mode,   // address bits 1:0
  output sw_access_t  acc
);
  always_comb begin
    acc.hit    = valid && (addr_page == WIN_BASE[15:4]);
    acc.is_rd  = rnw;
    acc.odd    = sel_mode[0];
    acc.rd_ram = (sel_mode == 2'b00) || (sel_mode == 2'b11);
    acc.bank1  = sel_bank;
  end
endmodule

// File: rtl/hrc_mode_regs.sv
module hrc_mode_regs
  import hrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sw_access_t acc,
  output logic       rd_en,
  output logic       bank1
);
  logic rd_en_d, bank1_d;
  logic upd_en;

  assign upd_en = acc.hit;

  always_comb begin
    rd_en_d = rd_en;
    bank1_d = bank1;
    if (upd_en) begin
      rd_en_d = acc.rd_ram;
      bank1_d = acc.bank1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en <= 1'b0;
      bank1 <= 1'b0;
    end else if (upd_en) begin
      rd_en <= rd_en_d;
      bank1 <= bank1_d;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc.hit |=> ($stable(rd_en) && $stable(bank1)));
  assert_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc.hit |=> (bank1 == $past(acc.bank1)));
  assert_read_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc.hit |=> (rd_en == $past(acc.rd_ram)));
endmodule

// File: rtl/hrc_prewrite_ctr.sv
module hrc_prewrite_ctr
  import hrc_pkg::*;
#(
  parameter int THRESH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sw_access_t acc,
  output logic       wr_en
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = acc.hit;

  always_comb begin
    cnt_d = cnt_q;
    if (acc.odd && acc.is_rd) begin
      if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wr_en = (cnt_q == LIMIT);

  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.hit && acc.odd && acc.is_rd && cnt_q == LIMIT - 1'b1) |=> wr_en);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.hit && !(acc.odd && acc.is_rd)) |=> !wr_en);
  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.hit && cnt_q == '0) |=> !wr_en);
endmodule

// File: rtl/hrc_region_map.sv
module hrc_region_map #(
  parameter logic [15:0] HI_BASE = 16'hD000
) (
  input  logic        valid,
  input  logic        rnw,
  input  logic [15:0] addr,
  input  logic        rd_en,
  input  logic        wr_en,
  output logic        route
);
  logic in_hi;

  always_comb begin
    in_hi = valid && (addr >= HI_BASE);
    route = in_hi && (rnw ? rd_en : wr_en);
  end
endmodule

// File: rtl/hiram_switch_ctrl.sv
module hiram_switch_ctrl
  import hrc_pkg::*;
#(
  parameter logic [15:0] WIN_BASE    = 16'hC080,
  parameter logic [15:0] HI_BASE     = 16'hD000,
  parameter int          WR_THRESH   = 2,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_rnw,
  input  logic [15:0] bus_addr,
  output logic        ram_rd_en,
  output logic        ram_wr_en,
  output logic        bank1_sel,
  output logic        ram_route
);
  logic       rst_n_s;
  sw_access_t acc;

  hrc_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  hrc_window_decode #(.WIN_BASE(WIN_BASE)) decode_i (
    .valid(bus_valid), .rnw(bus_rnw), .addr_page(bus_addr[15:4]),
    .sel_bank(bus_addr[3]), .sel_mode(bus_addr[1:0]), .acc(acc));

  hrc_mode_regs mode_i (
    .clk(clk), .rst_n(rst_n_s), .acc(acc),
    .rd_en(ram_rd_en), .bank1(bank1_sel));

  hrc_prewrite_ctr #(.THRESH(WR_THRESH)) ctr_i (
    .clk(clk), .rst_n(rst_n_s), .acc(acc), .wr_en(ram_wr_en));

  hrc_region_map #(.HI_BASE(HI_BASE)) map_i (
    .valid(bus_valid), .rnw(bus_rnw), .addr(bus_addr),
    .rd_en(ram_rd_en), .wr_en(ram_wr_en), .route(ram_route));

  assert_route_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_valid || bus_addr < HI_BASE) |-> !ram_route);
  assert_nowr_route_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_rnw && !ram_wr_en) |-> !ram_route);
  assert_wr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_valid && bus_addr[15:4] == WIN_BASE[15:4]) |=> $stable(ram_wr_en));
endmodule

// File: tb/hiram_switch_ctrl_tb_top.sv
module hiram_switch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_rnw = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        ram_rd_en, ram_wr_en, bank1_sel, ram_route;

  int n_chk = 0;
  int n_err = 0;
  logic m_rd, m_b1;
  int   m_cnt;

  always #4 clk = ~clk;

  hiram_switch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .bank1_sel(bank1_sel), .ram_route(ram_route));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " rd"}, ram_rd_en, m_rd);
    check({req, " bank"}, bank1_sel, m_b1);
    check({req, " wr"}, ram_wr_en, m_cnt >= 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_rd = 1'b0; m_b1 = 1'b0; m_cnt = 0;
  endtask

  // One access: driven after a falling edge, sampled at the next falling edge
  task automatic access(input logic [15:0] a, input logic rnw, input logic v);
    logic in_win;
    bus_addr = a; bus_rnw = rnw; bus_valid = v;
    #1;
    // R10: registered outputs unchanged before the edge
    check("R10 rd", ram_rd_en, m_rd);
    check("R10 wr", ram_wr_en, m_cnt >= 2);
    @(negedge clk);
    bus_valid = 1'b0;
    in_win = v && (a[15:4] == 12'hC08);
    if (in_win) begin
      m_b1 = a[3];
      m_rd = (a[1:0] == 2'b00) || (a[1:0] == 2'b11);
      if (a[0] && rnw) m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
      else             m_cnt = 0;
    end
  endtask

  task automatic route_probe(input logic [15:0] a, input logic rnw);
    logic exp;
    bus_addr = a; bus_rnw = rnw; bus_valid = 1'b1;
    #1;
    exp = (a >= 16'hD000) ? (rnw ? m_rd : (m_cnt >= 2)) : 1'b0;
    check("R9 route", ram_route, exp);
    bus_valid = 1'b0;
    #1;
    check("R9 route idle", ram_route, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 rd", ram_rd_en, 1'b0);
    check("R1 wr", ram_wr_en, 1'b0);
    check("R1 bank", bank1_sel, 1'b0);

    // R8: a single odd read does not enable writes
    access(16'hC081, 1'b1, 1'b1); check_state("R8 single");
    check("R8 single wr", ram_wr_en, 1'b0);
    // R6: second odd read enables writes
    access(16'hC081, 1'b1, 1'b1); check_state("R6 double");
    check("R6 double wr", ram_wr_en, 1'b1);
    // R7: an even access clears the count
    access(16'hC080, 1'b1, 1'b1); check_state("R7 even");
    // R8: odd read, odd write, odd read stays disabled
    access(16'hC08B, 1'b1, 1'b1);
    access(16'hC08B, 1'b0, 1'b1); check_state("R7 oddwrite");
    access(16'hC08B, 1'b1, 1'b1); check_state("R8 rd-wr-rd");
    check("R8 rd-wr-rd wr", ram_wr_en, 1'b0);

    // R2: accesses outside window or unqualified leave state alone
    access(16'hC08B, 1'b1, 1'b1);
    access(16'hC090, 1'b1, 1'b1); check_state("R2 above");
    access(16'hC07F, 1'b0, 1'b1); check_state("R2 below");
    access(16'hC080, 1'b1, 1'b0); check_state("R2 novalid");
    check("R2 wr kept", ram_wr_en, 1'b1);

    // R9 routing against several states
    route_probe(16'hD000, 1'b1); route_probe(16'hFFFF, 1'b0);
    route_probe(16'hCFFF, 1'b1); route_probe(16'hE123, 1'b1);
    access(16'hC082, 1'b1, 1'b1);
    route_probe(16'hD7FF, 1'b1); route_probe(16'hD7FF, 1'b0);

    // Exhaustive sweep: every offset, both directions, each pre-count
    for (int pre = 0; pre < 3; pre++) begin
      for (int off = 0; off < 16; off++) begin
        for (int rw = 0; rw < 2; rw++) begin
          access(16'hC08C, 1'b1, 1'b1);   // clear count (even)
          for (int k = 0; k < pre; k++) access(16'hC085, 1'b1, 1'b1);
          access(16'hC080 + 16'(off), rw[0], 1'b1);
          if (off[2]) check_state("R5 alias");
          else if (off[3]) check_state("R3 bank1");
          else check_state("R4 mode");
          route_probe(16'hD800, rw[0]);
        end
      end
    end

    do_reset();
    check("R1 again wr", ram_wr_en, 1'b0);
    check("R1 again rd", ram_rd_en, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule